// File: doc/BRIEF.md
# Signed Byte Decimal Display Driver

This block turns a two's-complement byte into the segment patterns for a row of seven-segment digits. The digits show the signed decimal value of the byte. Zeros in front of the value are blanked, and a negative value gets a minus sign in the position just left of its most significant digit. One enable input blanks the whole row. The logic is purely combinational and has no clock.

Inside, the block is a chain of identical digit stages. It starts at the rightmost digit. Each stage displays the remaining magnitude modulo ten and hands the quotient by ten to the stage on its left. It also hands on the control that decides whether that stage shows a digit, a minus sign or a blank. The byte width and the number of digits are parameters.

Top module: `signed_byte_dec_display`

## Requirements
- R1: While `enable_i` is low, every bit of `seg_o` is 1, so all digits are blank.
- R2: The segments are active low, packed as {g,f,e,d,c,b,a}. The digit codes are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000. The minus sign is 0111111 and a blank is 1111111.
- R3: When enabled, the units digit is always shown as a numeral, including when the value is 0.
- R4: Digit positions to the left of the most significant nonzero digit are blank, apart from the single minus sign described in R5.
- R5: For a negative input, exactly one minus sign appears, in the position directly left of the most significant digit.
- R6: The input -128 (8'h80) displays as minus, 1, 2, 8 across the four positions.
- R7: A nonnegative input never produces a minus sign.
- R8: `seg_o[6:0]` is the rightmost (units) digit. Each following group of seven bits is one position further left, and `seg_o[27:21]` is the leftmost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | VAL_W (8) | Two's-complement value to display |
| enable_i | input | 1 | High to display; low blanks all digits |
| seg_o | output | 7*DIGITS (28) | Active-low segment patterns, units digit in the low seven bits |

## Verification
The bench builds the block with its default parameters: an 8-bit value and four digit positions. With that width the whole input space is 256 values, so the bench sweeps every value with the display both enabled and disabled. This includes 128 as a magnitude, every one-, two- and three-digit length, and every placement of the minus sign. Randomly ordered values from a fixed seed and directed checks on the digit codes and the field order are added on top of the sweep.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_BLANK = 7'b1111111;
  localparam seg_t SEG_MINUS = 7'b0111111;

  // Decimal arithmetic shared by every stage
  function automatic logic [3:0] dec_mod(input int unsigned x);
    int unsigned r;
    r = x % 10;
    return r[3:0];
  endfunction

  function automatic int unsigned dec_div(input int unsigned x);
    return x / 10;
  endfunction

  // Active-low pattern, bit order {g,f,e,d,c,b,a}
  function automatic seg_t digit_pattern(input logic [3:0] d);
    seg_t p;
    case (d)
      4'd0:    p = 7'b1000000;
      4'd1:    p = 7'b1111001;
      4'd2:    p = 7'b0100100;
      4'd3:    p = 7'b0110000;
      4'd4:    p = 7'b0011001;
      4'd5:    p = 7'b0010010;
      4'd6:    p = 7'b0000010;
      4'd7:    p = 7'b1111000;
      4'd8:    p = 7'b0000000;
      4'd9:    p = 7'b0010000;
      default: p = SEG_BLANK;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sdd_sign_split.sv
module sdd_sign_split #(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] value_i,
  output logic             neg_o,
  output logic [VAL_W-1:0] mag_o
);
  localparam logic [VAL_W-1:0] MAG_LIMIT = {1'b1, {(VAL_W-1){1'b0}}};

  always_comb begin
    neg_o = value_i[VAL_W-1];
    mag_o = neg_o ? (~value_i + 1'b1) : value_i;
  end

  always_comb begin
    AST_MAG_IN_RANGE: assert (mag_o <= MAG_LIMIT); // R6
    if (neg_o) begin
      AST_NEG_NONZERO: assert (mag_o != '0); // R5
    end
  end
endmodule

// File: rtl/sdd_digit_stage.sv
module sdd_digit_stage
  import sdd_pkg::*;
#(
  parameter int MAG_W    = 8,
  parameter bit IS_UNITS = 1'b0
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic             neg_i,
  input  logic             en_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             neg_o,
  output logic             en_o,
  output seg_t             seg_o
);
  logic       zero_here;
  logic       show_digit;
  logic       show_sign;
  logic [3:0] digit;

  always_comb begin
    zero_here  = (mag_i == '0);
    show_digit = en_i && (!zero_here || IS_UNITS);
    show_sign  = en_i && zero_here && !IS_UNITS && neg_i;
    digit      = dec_mod(32'(mag_i));
    mag_o      = MAG_W'(dec_div(32'(mag_i)));
    neg_o      = neg_i;
    en_o       = show_digit;
    if (show_digit)     seg_o = digit_pattern(digit);
    else if (show_sign) seg_o = SEG_MINUS;
    else                seg_o = SEG_BLANK;
  end

  always_comb begin
    if (!en_i) begin
      AST_STAGE_OFF_BLANK: assert (seg_o == SEG_BLANK && !en_o); // R4
    end
    if (IS_UNITS && en_i) begin
      AST_UNITS_NUMERAL: assert (seg_o != SEG_BLANK && seg_o != SEG_MINUS); // R3
    end
    if (en_o) begin
      AST_DIGIT_BELOW_TEN: assert (digit <= 4'd9); // R2
    end
  end
endmodule

// File: rtl/signed_byte_dec_display.sv
module signed_byte_dec_display
  import sdd_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int DIGITS = 4
) (
  input  logic [VAL_W-1:0]        value_i,
  input  logic                    enable_i,
  output logic [SEG_W*DIGITS-1:0] seg_o
);
  logic [VAL_W-1:0] mag_c [0:DIGITS];
  logic             neg_c [0:DIGITS];
  logic             en_c  [0:DIGITS];

  sdd_sign_split #(.VAL_W(VAL_W)) u_sign (
    .value_i(value_i),
    .neg_o  (neg_c[0]),
    .mag_o  (mag_c[0])
  );

  assign en_c[0] = enable_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    sdd_digit_stage #(
      .MAG_W   (VAL_W),
      .IS_UNITS(i == 0)
    ) u_stage (
      .mag_i(mag_c[i]),
      .neg_i(neg_c[i]),
      .en_i (en_c[i]),
      .mag_o(mag_c[i+1]),
      .neg_o(neg_c[i+1]),
      .en_o (en_c[i+1]),
      .seg_o(seg_o[i*SEG_W +: SEG_W])
    );
  end

  // Number of minus signs across the row, for the checks below
  logic [$clog2(DIGITS+1)-1:0] minus_cnt;
  always_comb begin
    minus_cnt = '0;
    for (int k = 0; k < DIGITS; k++)
      if (seg_o[k*SEG_W +: SEG_W] == SEG_MINUS) minus_cnt = minus_cnt + 1'b1;
  end

  always_comb begin
    if (!enable_i) begin
      AST_DARK_WHEN_OFF: assert (&seg_o); // R1
    end
    if (enable_i && value_i[VAL_W-1]) begin
      AST_ONE_MINUS: assert (minus_cnt == 1); // R5
    end
    if (!value_i[VAL_W-1]) begin
      AST_NO_MINUS_POS: assert (minus_cnt == 0); // R7
    end
    AST_CHAIN_FITS: assert (mag_c[DIGITS] == '0 && !(en_c[DIGITS] && neg_c[DIGITS])); // R4
  end
endmodule

// File: tb/test_signed_byte_dec_display.sv
module test_signed_byte_dec_display;
  logic        clk = 1'b0;
  logic [7:0]  value_i = '0;
  logic        enable_i = 1'b0;
  logic [27:0] seg_o;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  signed_byte_dec_display i_signed_byte_dec_display (
    .value_i (value_i),
    .enable_i(enable_i),
    .seg_o   (seg_o)
  );

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'b1000000;  1: return 7'b1111001;
      2: return 7'b0100100;  3: return 7'b0110000;
      4: return 7'b0011001;  5: return 7'b0010010;
      6: return 7'b0000010;  7: return 7'b1111000;
      8: return 7'b0000000;  9: return 7'b0010000;
      default: return 7'b1111111;
    endcase
  endfunction

  // Expected row: count significant digits, then place digits, sign, blanks
  function automatic logic [27:0] model(input logic [7:0] v, input bit en);
    logic [27:0] r;
    int sv, m, len, t;
    r = '1;
    if (!en) return r;
    sv = $signed(v);
    m = (sv < 0) ? -sv : sv;
    len = 1;
    t = m;
    while (t >= 10) begin t = t / 10; len++; end
    t = m;
    for (int p = 0; p < 4; p++) begin
      if (p < len) r[p*7 +: 7] = pat(t % 10);
      else if (p == len && sv < 0) r[p*7 +: 7] = 7'b0111111;
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [27:0] exp);
    @(negedge clk);
    n_checks++;
    if (seg_o !== exp) begin
      n_fail++;
      $display("FAIL %s value=%0d en=%0b actual=%b expected=%b",
               tag, $signed(value_i), enable_i, seg_o, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v, input bit en);
    @(posedge clk);
    value_i  = v;
    enable_i = en;
  endtask

  function automatic string tag_of(input logic [7:0] v, input bit en);
    if (!en) return "R1";
    if (v == 8'h00) return "R3";
    if (v == 8'h80) return "R6";
    if (v[7]) return "R5";
    return "R4";
  endfunction

  initial begin
    #20000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    // Reset state: disabled, all blank (R1)
    apply(8'h00, 1'b0);
    check("R1", 28'hFFFFFFF);
    // R2: each digit code on the units field
    for (int d = 0; d < 10; d++) begin
      apply(8'(d), 1'b1);
      check("R2", {21'h1FFFFF, pat(d)});
    end
    // R8: units in low bits, leftmost field in the top bits
    apply(8'd107, 1'b1);
    check("R8", {7'b1111111, 7'b1111001, 7'b1000000, 7'b1111000});
    // R6: -128 shows minus 1 2 8
    apply(8'h80, 1'b1);
    check("R6", {7'b0111111, 7'b1111001, 7'b0100100, 7'b0000000});
    // R5: -1 shows blank blank minus 1
    apply(8'hFF, 1'b1);
    check("R5", {7'b1111111, 7'b1111111, 7'b0111111, 7'b1111001});
    // R7: 127 without sign
    apply(8'd127, 1'b1);
    check("R7", {7'b1111111, 7'b1111001, 7'b0100100, 7'b1111000});
    // R3: zero shows a single 0
    apply(8'd0, 1'b1);
    check("R3", {21'h1FFFFF, 7'b1000000});
    // Exhaustive sweep, enabled and disabled
    for (int v = 0; v < 256; v++) begin
      for (int e = 0; e < 2; e++) begin
        apply(8'(v), e[0]);
        check(tag_of(8'(v), e[0]), model(8'(v), e[0]));
      end
    end
    // Random order from a fixed seed
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      rv = 8'($urandom);
      apply(rv, ($urandom % 8) != 0);
      check(tag_of(rv, enable_i), model(rv, enable_i));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule